// File: doc/BRIEF.md
# Hierarchical Base-4 Next-Hop Selector

This block picks the next routing step for a cell inside a multi-level switching fabric. The fabric is built from clusters of 4x4 nodes, and those clusters are joined into larger networks level by level. The current node address and the destination address both enter as packed vectors of base-4 digit pairs, one pair per hierarchy level. The block compares the two addresses and finds the highest level at which they differ. Cells always move top-down through the hierarchy.

When that level is above the cluster, the cell first has to reach the node inside its present cluster that owns the link for that level. The block names that outlet node and gives the single in-cluster step toward it. Once the cell stands on the outlet, the block tells it to leave through that node's free link. When only the cluster-local pair differs, the block steers straight toward the destination node. When the addresses are equal, it reports delivery.

Decisions are registered, so a result appears one clock after its inputs. The decision logic sorts each address pair into one of three classes. HOME means the two addresses are identical. LOCAL means only level 1 differs. OUTLET means a higher level differs. The block uses a `unique case` over these classes. There is no sequential state beyond the output register.

Top module: `route_sel`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `hop_level`, `hop_node` and `hop_move` are all zero.
- R2: Each decision appears on the outputs one clock after the inputs it belongs to. The move codes are: 0 deliver, 1 up (row minus one), 2 down (row plus one), 3 left (column minus one), 4 right (column plus one), 5 exit through the node's free link.
- R3: Address bits [4k-1:4k-4] hold the pair for level k, so the highest level sits at the most significant end. Within a pair, the upper two bits are the row digit and the lower two bits are the column digit.
- R4: `hop_level` is the highest level whose pairs differ, or 0 when the two addresses are equal.
- R5: When the addresses are equal, `hop_move` is deliver and `hop_node` is the current node's level-1 pair.
- R6: When only the level-1 pair differs, `hop_level` is 1 and `hop_node` is the destination's level-1 pair.
- R7: The in-cluster step from the current node toward `hop_node` corrects the column first, using left or right. Once the columns match, it corrects the row, using up or down.
- R8: When `hop_level` is 2 or more, `hop_node` is that level's outlet node. `hop_move` is exit exactly when the current node already is that outlet.
- R9: The outlet is taken from a horizontal table when the column digits of the differing level's pair differ, and from a vertical table otherwise. In a two-level fabric the defaults are node 31 (row 3, column 1, code 4'hD) for horizontal and node 20 (code 4'h8) for vertical.
- R10: Repeatedly following the block's decisions brings a cell to its destination in a two-level fabric. On every hop, the cell never steps off the cluster grid. A horizontal exit advances the cluster column by one modulo 4, and a vertical exit advances the cluster row by one modulo 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_addr | input | 4*LEVELS | Current node address, as base-4 pairs |
| dst_addr | input | 4*LEVELS | Destination address, as base-4 pairs |
| hop_level | output | clog2(LEVELS+1) | Highest differing level, or 0 when the addresses match |
| hop_node | output | 4 | Cluster-local target node (row, column) |
| hop_move | output | 3 | Move code for this hop |

## Verification
The bench sweeps every pair of two-level addresses. This sweep catches a selector that takes the lowest differing level instead of the highest, or that swaps the row and column digits. Either fault would send cells to the wrong outlet or deliver them early. The bench also drives a cell that already stands on its outlet, where a broken selector would keep stepping inside the cluster instead of exiting. It drives a pair that differs only in its row digit at level 2, where a wrong table choice would pick the horizontal outlet. Finally, it follows cells hop by hop across the fabric. A row-first step order, a flipped direction sign, or a bad exit choice would then show up as a cell leaving the grid or never arriving.

// File: rtl/route_sel_pkg.sv
package route_sel_pkg;
    localparam int NODE_W = 4;

    typedef enum logic [2:0] {
        MV_DELIVER = 3'd0,
        MV_UP      = 3'd1,
        MV_DOWN    = 3'd2,
        MV_LEFT    = 3'd3,
        MV_RIGHT   = 3'd4,
        MV_EXIT    = 3'd5
    } move_t;

    typedef enum logic [1:0] {
        CL_HOME   = 2'd0,
        CL_LOCAL  = 2'd1,
        CL_OUTLET = 2'd2
    } class_t;
endpackage

// File: rtl/level_finder.sv
module level_finder #(
    parameter int LEVELS = 2,
    parameter int LW     = $clog2(LEVELS + 1)
) (
    input  logic [4*LEVELS-1:0] cur,
    input  logic [4*LEVELS-1:0] dst,
    output logic [LW-1:0]       lvl,
    output logic                col_diff
);
    // Scan upward so the highest differing pair is the last one written.
    always_comb begin
        lvl      = '0;
        col_diff = 1'b0;
        for (int k = 1; k <= LEVELS; k++) begin
            if (cur[4*k-1 -: 4] != dst[4*k-1 -: 4]) begin
                lvl      = LW'(k);
                col_diff = (cur[4*k-3 -: 2] != dst[4*k-3 -: 2]);
            end
        end
    end
endmodule

// File: rtl/outlet_pick.sv
module outlet_pick #(
    parameter int                  LEVELS   = 2,
    parameter int                  LW       = $clog2(LEVELS + 1),
    parameter logic [4*LEVELS-1:0] OUTLET_H = '0,
    parameter logic [4*LEVELS-1:0] OUTLET_V = '0
) (
    input  logic [LW-1:0] lvl,
    input  logic          col_diff,
    output logic [3:0]    node
);
    always_comb begin
        node = '0;
        for (int k = 2; k <= LEVELS; k++) begin
            if (lvl == LW'(k)) begin
                node = col_diff ? OUTLET_H[4*k-1 -: 4] : OUTLET_V[4*k-1 -: 4];
            end
        end
    end
endmodule

// File: rtl/cluster_step.sv
module cluster_step
    import route_sel_pkg::*;
(
    input  logic [3:0] here,
    input  logic [3:0] there,
    output move_t      mv
);
    logic [1:0] here_row, here_col, there_row, there_col;

    assign here_row  = here[3:2];
    assign here_col  = here[1:0];
    assign there_row = there[3:2];
    assign there_col = there[1:0];

    // Column first, then row; equal position means the cell sits on the target.
    always_comb begin
        if (there_col > here_col)      mv = MV_RIGHT;
        else if (there_col < here_col) mv = MV_LEFT;
        else if (there_row > here_row) mv = MV_DOWN;
        else if (there_row < here_row) mv = MV_UP;
        else                           mv = MV_EXIT;
    end
endmodule

// File: rtl/route_sel.sv
module route_sel
    import route_sel_pkg::*;
#(
    parameter int                  LEVELS   = 2,
    parameter int                  LW       = $clog2(LEVELS + 1),
    parameter logic [4*LEVELS-1:0] OUTLET_H = 8'hD0,
    parameter logic [4*LEVELS-1:0] OUTLET_V = 8'h80
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [4*LEVELS-1:0] cur_addr,
    input  logic [4*LEVELS-1:0] dst_addr,
    output logic [LW-1:0]       hop_level,
    output logic [3:0]          hop_node,
    output logic [2:0]          hop_move
);
    logic [LW-1:0] diff_lvl;
    logic          diff_col;
    logic [3:0]    outlet_node;
    logic [3:0]    target_c;
    move_t         step_mv;
    move_t         move_c;
    class_t        cls;

    level_finder #(.LEVELS(LEVELS), .LW(LW)) u_find (
        .cur      (cur_addr),
        .dst      (dst_addr),
        .lvl      (diff_lvl),
        .col_diff (diff_col)
    );

    outlet_pick #(
        .LEVELS   (LEVELS),
        .LW       (LW),
        .OUTLET_H (OUTLET_H),
        .OUTLET_V (OUTLET_V)
    ) u_outlet (
        .lvl      (diff_lvl),
        .col_diff (diff_col),
        .node     (outlet_node)
    );

    cluster_step u_step (
        .here  (cur_addr[3:0]),
        .there (target_c),
        .mv    (step_mv)
    );

    always_comb begin
        if (diff_lvl == '0)             cls = CL_HOME;
        else if (diff_lvl == LW'(1))    cls = CL_LOCAL;
        else                            cls = CL_OUTLET;
    end

    always_comb begin
        unique case (cls)
            CL_HOME: begin
                target_c = cur_addr[3:0];
                move_c   = MV_DELIVER;
            end
            CL_LOCAL: begin
                target_c = dst_addr[3:0];
                move_c   = step_mv;
            end
            CL_OUTLET: begin
                target_c = outlet_node;
                move_c   = step_mv;
            end
            default: begin
                target_c = cur_addr[3:0];
                move_c   = MV_DELIVER;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hop_level <= '0;
            hop_node  <= '0;
            hop_move  <= MV_DELIVER;
        end else begin
            hop_level <= diff_lvl;
            hop_node  <= target_c;
            hop_move  <= move_c;
        end
    end
endmodule

// File: rtl/route_sel_chk.sv
module route_sel_chk #(
    parameter int LEVELS = 2,
    parameter int LW     = $clog2(LEVELS + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [4*LEVELS-1:0] cur_addr,
    input logic [4*LEVELS-1:0] dst_addr,
    input logic [LW-1:0]       hop_level,
    input logic [3:0]          hop_node,
    input logic [2:0]          hop_move
);
    logic primed;

    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    // R2
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        hop_move <= 3'd5);

    // R5
    home_deliver_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        $past(cur_addr == dst_addr) |->
            (hop_move == 3'd0 && hop_level == '0 && hop_node == $past(cur_addr[3:0])));

    // R6
    local_target_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        $past((cur_addr >> 4) == (dst_addr >> 4) && cur_addr[3:0] != dst_addr[3:0]) |->
            (hop_level == LW'(1) && hop_node == $past(dst_addr[3:0])));

    // R8
    exit_here_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        hop_move == 3'd5 |-> (hop_node == $past(cur_addr[3:0]) && hop_level >= LW'(2)));

    // R7
    left_step_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        hop_move == 3'd3 |-> $past(cur_addr[1:0]) > hop_node[1:0]);

    // R7
    right_step_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
        hop_move == 3'd4 |-> $past(cur_addr[1:0]) < hop_node[1:0]);
endmodule

bind route_sel route_sel_chk #(.LEVELS(LEVELS), .LW(LW)) u_route_sel_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur_addr  (cur_addr),
    .dst_addr  (dst_addr),
    .hop_level (hop_level),
    .hop_node  (hop_node),
    .hop_move  (hop_move)
);

// File: tb/route_sel_bench.sv
module route_sel_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cur_addr = '0;
    logic [7:0] dst_addr = '0;
    logic [1:0] hop_level;
    logic [3:0] hop_node;
    logic [2:0] hop_move;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    route_sel u_route_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_addr  (cur_addr),
        .dst_addr  (dst_addr),
        .hop_level (hop_level),
        .hop_node  (hop_node),
        .hop_move  (hop_move)
    );

    // Expected {level, node, move} from the requirements (R4..R9).
    function automatic logic [8:0] model(input logic [7:0] c, input logic [7:0] d);
        logic [1:0] lv;
        logic [3:0] tn;
        logic [2:0] mv;
        if (c == d) return {2'd0, c[3:0], 3'd0};
        if (c[7:4] != d[7:4]) begin
            lv = 2'd2;
            tn = (c[5:4] != d[5:4]) ? 4'hD : 4'h8;
        end else begin
            lv = 2'd1;
            tn = d[3:0];
        end
        if (c[1:0] < tn[1:0])      mv = 3'd4;
        else if (c[1:0] > tn[1:0]) mv = 3'd3;
        else if (c[3:2] < tn[3:2]) mv = 3'd2;
        else if (c[3:2] > tn[3:2]) mv = 3'd1;
        else                       mv = 3'd5;
        return {lv, tn, mv};
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [7:0] c, input logic [7:0] d);
        @(negedge clk);
        cur_addr = c;
        dst_addr = d;
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        cur_addr = 8'h5A;
        dst_addr = 8'hC3;
        repeat (3) @(negedge clk);
        check("R1 in reset", {hop_level, hop_node, hop_move}, 9'd0);
        rst_n = 1'b1;
        check("R1 after release", {hop_level, hop_node, hop_move}, 9'd0);
    endtask

    task automatic t_directed;
        step(8'h37, 8'h37);
        check("R5 equal addresses", {hop_level, hop_node, hop_move}, {2'd0, 4'h7, 3'd0});
        step(8'h20, 8'h2F);
        check("R6 R7 right then down", {hop_level, hop_node, hop_move}, {2'd1, 4'hF, 3'd4});
        step(8'h2F, 8'h23);
        check("R7 same column go up", {hop_level, hop_node, hop_move}, {2'd1, 4'h3, 3'd1});
        step(8'h0D, 8'h10);
        check("R8 R9 at horizontal outlet", {hop_level, hop_node, hop_move}, {2'd2, 4'hD, 3'd5});
        step(8'h08, 8'h40);
        check("R8 R9 at vertical outlet", {hop_level, hop_node, hop_move}, {2'd2, 4'h8, 3'd5});
        step(8'h00, 8'h40);
        check("R9 row-only difference picks vertical", {hop_level, hop_node, hop_move}, {2'd2, 4'h8, 3'd2});
        step(8'h03, 8'hF3);
        check("R3 R4 top level wins", {hop_level, hop_node, hop_move}, {2'd2, 4'hD, 3'd3});
    endtask

    // R2: a new input each cycle, the result checked one cycle later.
    task automatic t_sweep;
        logic [7:0] pc = '0;
        logic [7:0] pd = '0;
        logic       have = 1'b0;
        for (int c = 0; c < 256; c++) begin
            for (int d = 0; d < 256; d++) begin
                @(negedge clk);
                if (have) check("R2 R4 sweep", {hop_level, hop_node, hop_move}, model(pc, pd));
                cur_addr = 8'(c);
                dst_addr = 8'(d);
                pc = 8'(c);
                pd = 8'(d);
                have = 1'b1;
            end
        end
        @(negedge clk);
        check("R2 R4 sweep", {hop_level, hop_node, hop_move}, model(pc, pd));
    endtask

    task automatic walk(input logic [7:0] src, input logic [7:0] dst);
        logic [7:0] pos = src;
        logic       ok = 1'b0;
        logic       off = 1'b0;
        for (int h = 0; h < 60 && !ok && !off; h++) begin
            step(pos, dst);
            case (hop_move)
                3'd0: ok = (pos == dst);
                3'd1: if (pos[3:2] == 2'd0) off = 1'b1; else pos[3:2] = pos[3:2] - 2'd1;
                3'd2: if (pos[3:2] == 2'd3) off = 1'b1; else pos[3:2] = pos[3:2] + 2'd1;
                3'd3: if (pos[1:0] == 2'd0) off = 1'b1; else pos[1:0] = pos[1:0] - 2'd1;
                3'd4: if (pos[1:0] == 2'd3) off = 1'b1; else pos[1:0] = pos[1:0] + 2'd1;
                3'd5: if (hop_node == 4'hD) pos[5:4] = pos[5:4] + 2'd1;
                      else if (hop_node == 4'h8) pos[7:6] = pos[7:6] + 2'd1;
                      else off = 1'b1;
                default: off = 1'b1;
            endcase
        end
        check("R10 convergence", {1'b0, ok, pos[6:0] & 7'h0}, {1'b0, 1'b1, 7'h0});
        if (!ok) $display("      R10 source=%h destination=%h stopped at %h", src, dst, pos);
    endtask

    task automatic t_converge;
        walk(8'h00, 8'hFF);
        walk(8'hFF, 8'h00);
        walk(8'h0D, 8'h0D);
        for (int i = 0; i < 64; i++) walk(8'((i * 37) & 255), 8'((i * 101 + 7) & 255));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 180000) begin
                bad++;
                total++;
                $display("FAIL watchdog expired");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        t_reset();
        t_directed();
        t_sweep();
        t_converge();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule